// File: doc/BRIEF.md
# FIFO Pointer and Flag Controller

This block steers a separate two-port RAM of 32 eight-bit words so that the RAM behaves as a first-in first-out queue. Outside devices raise a read request or a write request. The controller turns each request into a RAM read strobe or a RAM write strobe, and it grants the request only when the queue can take the operation. It also drives the address of the next word to read and the address of the next word to write, and it reports whether the queue is empty or full.

The controller stores no data and keeps no occupancy counter. It works out the empty and full states from the way the two pointers move. A read that makes the two pointers equal means the queue is empty. A write that makes them equal means the queue is full. Reads and writes run on the same clock, and the controller can grant one of each in the same cycle.

Top module: `fifo_ptr_ctrl`

## Requirements
- R1: When the synchronous active-high reset `rst` is high at a rising clock edge, both address outputs go to 0, `is_empty` goes high and `is_full` goes low.
- R2: `ram_re` is high in a cycle exactly when `req_rd` is high and `is_empty` is low. It is combinational from the current inputs and state.
- R3: `ram_we` is high in a cycle exactly when `req_wr` is high and `is_full` is low. It is combinational from the current inputs and state.
- R4: Each address output moves up by one at the clock edge that ends a cycle in which its strobe is high, and it wraps from 31 to 0. In any other cycle it holds its value.
- R5: A cycle that grants only a read sets `is_empty` high when the new read address equals the write address. A cycle that grants only a write sets `is_full` high when the new write address equals the read address.
- R6: A cycle that grants only a write clears `is_empty`. A cycle that grants only a read clears `is_full`.
- R7: When a read and a write are both granted in one cycle, both addresses advance and both flags keep their values.
- R8: When the queue is empty and both requests are high, only the write is granted. When the queue is full and both requests are high, only the read is granted.
- R9: `is_empty` and `is_full` are never high together. While either of them is high, the two address outputs are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_wr | input | 1 | Write request from the outside device |
| req_rd | input | 1 | Read request from the outside device |
| ram_we | output | 1 | Write strobe to the RAM |
| ram_re | output | 1 | Read strobe to the RAM |
| rd_addr | output | 5 | Address of the next word to read |
| wr_addr | output | 5 | Address of the next word to write |
| is_empty | output | 1 | High when the queue holds no words |
| is_full | output | 1 | High when the queue holds 32 words |

## Verification
The flags are the only record of whether equal pointers mean empty or full, so a wrong flag shows at the ports at once. In the same cycle, a request that should be granted is refused, or a request that should be refused is granted. A pointer that skips, stalls or wraps at the wrong point leaves the pointer difference out of step with the count of granted operations. The error shows on the address outputs one edge later, and it also makes the flags wrong the next time the queue fills or empties. The bench keeps an arithmetic occupancy model and compares it with the strobes, addresses and flags every cycle. The first wrong value is therefore reported in the cycle it appears.

// File: rtl/fifo_ptr_ctrl_pkg.sv
package fifo_ptr_ctrl_pkg;

    // Kind of transfer granted in one cycle; bit 0 = read, bit 1 = write.
    typedef enum logic [1:0] {
        XFER_NONE = 2'b00,
        XFER_POP  = 2'b01,
        XFER_PUSH = 2'b10,
        XFER_BOTH = 2'b11
    } xfer_e;

    // Occupancy state derived from pointer movement.
    typedef struct packed {
        logic empty;
        logic full;
    } flag_s;

    localparam flag_s FLAGS_AT_RESET = '{empty: 1'b1, full: 1'b0};

    // Index of each pointer in the pointer bank.
    localparam int PTR_RD  = 0;
    localparam int PTR_WR  = 1;
    localparam int NUM_PTR = 2;

    function automatic xfer_e classify(input logic pop, input logic push);
        return xfer_e'({push, pop});
    endfunction

endpackage

// File: rtl/fifo_req_gate.sv
module fifo_req_gate
    import fifo_ptr_ctrl_pkg::*;
(
    input  logic  req_rd,
    input  logic  req_wr,
    input  flag_s flags,
    output logic  pop,
    output logic  push,
    output xfer_e xfer
);

    // A read needs something to read, a write needs room to write.
    always_comb begin
        pop  = req_rd && !flags.empty;
        push = req_wr && !flags.full;
        xfer = classify(pop, push);
    end

endmodule

// File: rtl/fifo_ptr_reg.sv
module fifo_ptr_reg #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_inc
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    assign ptr_inc = wrap_inc(ptr);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (step) ptr <= ptr_inc;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + AW'(1))); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(ptr)); // R4

endmodule

// File: rtl/fifo_flag_track.sv
module fifo_flag_track
    import fifo_ptr_ctrl_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_e         xfer,
    input  logic [AW-1:0] rd_cur,
    input  logic [AW-1:0] wr_cur,
    input  logic [AW-1:0] rd_inc,
    input  logic [AW-1:0] wr_inc,
    output flag_s         flags
);

    flag_s flags_d;

    // Equal pointers are ambiguous; the operation that made them equal decides.
    always_comb begin
        flags_d = flags;
        unique case (xfer)
            XFER_POP: begin
                flags_d.empty = (rd_inc == wr_cur);
                flags_d.full  = 1'b0;
            end
            XFER_PUSH: begin
                flags_d.full  = (wr_inc == rd_cur);
                flags_d.empty = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= FLAGS_AT_RESET;
        else     flags <= flags_d;
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flags.empty && flags.full)); // R9

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        xfer == XFER_BOTH |=> $stable(flags)); // R7

    AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        xfer == XFER_PUSH |=> !flags.empty); // R6

    AST_POP_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
        xfer == XFER_POP |=> !flags.full); // R6

endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
    import fifo_ptr_ctrl_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_wr,
    input  logic          req_rd,
    output logic          ram_we,
    output logic          ram_re,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          is_empty,
    output logic          is_full
);

    flag_s         flags;
    xfer_e         xfer;
    logic          pop;
    logic          push;
    logic          step_v  [NUM_PTR];
    logic [AW-1:0] ptr_q   [NUM_PTR];
    logic [AW-1:0] ptr_inc [NUM_PTR];

    fifo_req_gate u_gate (
        .req_rd (req_rd),
        .req_wr (req_wr),
        .flags  (flags),
        .pop    (pop),
        .push   (push),
        .xfer   (xfer)
    );

    assign step_v[PTR_RD] = pop;
    assign step_v[PTR_WR] = push;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        fifo_ptr_reg #(.DEPTH(DEPTH)) u_ptr (
            .clk     (clk),
            .rst     (rst),
            .step    (step_v[g]),
            .ptr     (ptr_q[g]),
            .ptr_inc (ptr_inc[g])
        );
    end

    fifo_flag_track #(.DEPTH(DEPTH)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .xfer   (xfer),
        .rd_cur (ptr_q[PTR_RD]),
        .wr_cur (ptr_q[PTR_WR]),
        .rd_inc (ptr_inc[PTR_RD]),
        .wr_inc (ptr_inc[PTR_WR]),
        .flags  (flags)
    );

    assign ram_re   = pop;
    assign ram_we   = push;
    assign rd_addr  = ptr_q[PTR_RD];
    assign wr_addr  = ptr_q[PTR_WR];
    assign is_empty = flags.empty;
    assign is_full  = flags.full;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        ram_re |-> !is_empty); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !is_full); // R3

    AST_FLAG_PTRS_EQ: assert property (@(posedge clk) disable iff (rst)
        (is_empty || is_full) |-> rd_addr == wr_addr); // R9

    AST_EMPTY_BOTH_REQ: assert property (@(posedge clk) disable iff (rst)
        (is_empty && req_rd && req_wr) |-> (ram_we && !ram_re)); // R8

    AST_FULL_BOTH_REQ: assert property (@(posedge clk) disable iff (rst)
        (is_full && req_rd && req_wr) |-> (ram_re && !ram_we)); // R8

    AST_LAST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (ram_re && !ram_we && ptr_inc[PTR_RD] == wr_addr) |=> is_empty); // R5

    AST_LAST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !ram_re && ptr_inc[PTR_WR] == rd_addr) |=> is_full); // R5

endmodule

// File: tb/fifo_ptr_ctrl_bench.sv
`timescale 1ns/1ps
module fifo_ptr_ctrl_bench;

    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_wr = 1'b0;
    logic          req_rd = 1'b0;
    logic          ram_we, ram_re, is_empty, is_full;
    logic [AW-1:0] rd_addr, wr_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Arithmetic reference: occupancy count and two modulo counters.
    int    m_cnt = 0;
    int    m_rp  = 0;
    int    m_wp  = 0;
    string m_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_fifo_ptr_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_wr   (req_wr),
        .req_rd   (req_rd),
        .ram_we   (ram_we),
        .ram_re   (ram_re),
        .rd_addr  (rd_addr),
        .wr_addr  (wr_addr),
        .is_empty (is_empty),
        .is_full  (is_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_state(input string tag);
        chk({tag, " rd_addr R4"}, int'(rd_addr), m_rp);
        chk({tag, " wr_addr R4"}, int'(wr_addr), m_wp);
        chk({tag, " is_empty"}, int'(is_empty), int'(m_cnt == 0));
        chk({tag, " is_full"},  int'(is_full),  int'(m_cnt == DEPTH));
        if (is_empty || is_full)
            chk("R9 pointers equal under a flag", int'(rd_addr), int'(wr_addr));
    endtask

    task automatic step(input logic r, input logic w);
        bit exp_re, exp_we;
        @(negedge clk);
        req_rd = r;
        req_wr = w;
        #1;
        exp_re = r && (m_cnt != 0);
        exp_we = w && (m_cnt != DEPTH);
        check_state(m_tag);
        chk((r && w) ? "R8 read strobe"  : "R2 read strobe",  int'(ram_re), int'(exp_re));
        chk((r && w) ? "R8 write strobe" : "R3 write strobe", int'(ram_we), int'(exp_we));
        if (exp_re && exp_we)      m_tag = "R7";
        else if (r && w)           m_tag = "R8";
        else if (exp_re)           m_tag = (m_cnt == 1) ? "R5" : "R6";
        else if (exp_we)           m_tag = (m_cnt == DEPTH - 1) ? "R5" : "R6";
        else                       m_tag = "R4";
        m_cnt = m_cnt + int'(exp_we) - int'(exp_re);
        m_rp  = (m_rp + int'(exp_re)) % DEPTH;
        m_wp  = (m_wp + int'(exp_we)) % DEPTH;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst    = 1'b1;
        req_rd = 1'b1;
        req_wr = 1'b1;
        @(negedge clk);
        #1;
        m_cnt = 0; m_rp = 0; m_wp = 0;
        check_state("R1 reset");
        rst    = 1'b0;
        req_rd = 1'b0;
        req_wr = 1'b0;
        m_tag  = "R1";
    endtask

    // Biased pseudo-random traffic; rd_w and wr_w are weights out of 4.
    task automatic traffic(input int cycles, input int rd_w, input int wr_w);
        for (int i = 0; i < cycles; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(int'(lfsr[1:0]) < rd_w, int'(lfsr[5:4]) < wr_w);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);                                // R2: read refused at empty
        step(1'b1, 1'b1);                                // R8: empty, both -> write only
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1); // R3, R5: fill, extra refused
        step(1'b1, 1'b1);                                // R8: full, both -> read only
        step(1'b0, 1'b1);                                // R5: refill to full
        for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0); // R2, R5: drain, extra refused
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1);   // R7: both advance, wrap R4
        traffic(800, 1, 3);
        traffic(800, 3, 1);
        traffic(800, 2, 2);
        traffic(400, 3, 3);
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
        do_reset();                                      // R1: mid-run reset
        step(1'b1, 1'b0);
        traffic(600, 2, 3);
        traffic(600, 3, 2);
        step(1'b0, 1'b0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule